// File: doc/BRIEF.md
# Packet-to-Host DMA Writer

This block copies packets that already sit in local buffer memory into host memory through a master write port. A small descriptor ring feeds it. Each entry gives a byte count and the index of the local buffer block that holds the packet. When the ring holds at least one entry, the engine takes the oldest one and reads the packet words from the local buffer port. It writes them to the host as bursts of eight 32-bit beats.

Every entry owns one fixed-size block in host memory. The block is chosen by the entry's ring slot. The payload starts eight words into that block, and words 1 to 7 are left for software. After the last payload burst, a single-beat status word is written to word 0 of the block. Once that beat is accepted, the block does three things: it pulses the interrupt, it retires the ring entry, and it clears the local block's bit in the in-use bitmap. A new transfer is taken only after this completes.

The local read port and the host write port are modelled as simple handshakes:
- Local read port: request/grant, with read data valid in the grant cycle.
- Host write port: request/grant for the address phase, then valid/ready for the data beats.

Top module: `pkt_host_dma`

## Requirements
- R1: The host port and the local read port stay idle (`mw_req_o`, `mw_valid_o` and `lrd_req_o` low) whenever no descriptor is queued.
- R2: A descriptor is accepted when `push_valid_i` and `push_ready_o` are both high. The ring holds 16 entries, and `push_ready_o` is low while it is full. A push offered while the ring is full is ignored and produces no transfer.
- R3: For a byte count C, ceil(C/4) payload words are copied. Payload word w is read from local address {block, w[5:0]} (64 words per block). It is written to host word 8+w of the destination block.
- R4: The destination block base is `host_base_i` + slot*256, where slot is the ring position modulo 16. Payload goes out in ceil(ceil(C/4)/8) bursts. Each burst has one address phase, at base + 32 + 32k for burst k, followed by exactly eight beats, with `mw_last_o` on the eighth.
- R5: When ceil(C/4) is not a multiple of eight, the final burst is filled with zero words. A byte count of 0 produces no payload burst.
- R6: Host words 1 to 7 of the block, and every word past the final payload burst, are never written.
- R7: After the last payload beat, one single-beat write goes to word 0 of the block. Its address phase has `mw_single_o` high. It carries the byte count in bits [15:0] and the local block index in bits [16+]. This is the last write of the transfer.
- R8: In the cycle after the status beat is accepted, `irq_o` is high for exactly one cycle. The ring entry is retired, and the block's bit in `blk_used_o` reads 0 from the following cycle.
- R9: An accepted push sets bit `push_blk_i` of `blk_used_o` from the next cycle.
- R10: A pending address phase holds its address and type, and a pending data beat holds its data and last flag, until accepted. A pending local read holds its address until granted.
- R11: During reset all requests, `irq_o` and `blk_used_o` are low and `push_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_base_i | input | 32 | Byte address of host block 0 |
| push_valid_i | input | 1 | Descriptor offered |
| push_ready_o | output | 1 | Ring not full |
| push_cnt_i | input | 16 | Packet byte count |
| push_blk_i | input | 4 | Local buffer block index |
| lrd_req_o | output | 1 | Local word read request |
| lrd_addr_o | output | 10 | Local word address {block, word} |
| lrd_gnt_i | input | 1 | Read grant; data valid this cycle |
| lrd_data_i | input | 32 | Local read data |
| mw_req_o | output | 1 | Host write address phase request |
| mw_single_o | output | 1 | Address phase is the single status write |
| mw_addr_o | output | 32 | Host byte address of the write |
| mw_gnt_i | input | 1 | Address phase accepted |
| mw_valid_o | output | 1 | Data beat valid |
| mw_data_o | output | 32 | Data beat |
| mw_last_o | output | 1 | Final beat of a burst or status write |
| mw_ready_i | input | 1 | Data beat accepted |
| irq_o | output | 1 | Transfer-complete pulse |
| blk_used_o | output | 16 | Local blocks held by queued descriptors |

## Verification
Most internal faults show up in the host image that the block leaves behind. A wrong word index or burst counter shifts or truncates the payload. It can also corrupt the zero padding, or touch a reserved word or a word past the last burst. All of these show in the image within the transfer in which they occur. A faulty ring pointer or slot register puts the next transfer into the wrong host block, or starts a transfer that was never queued. The first shows at the next completion. The second shows as host activity while the bench holds an empty queue. The bench sweeps every byte count from 0 to 224, with grants throttled by a pseudo-random pattern. It also fills the ring to capacity with the host stalled, so each of these faults shows as a content, address or count mismatch at the interrupt that ends the affected transfer.

// File: rtl/pkt_dma_pkg.sv
package pkt_dma_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned CNT_W     = 16;
  localparam int unsigned BURST_LEN = 8;
  localparam int unsigned RSV_WORDS = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_BADDR, ST_BDATA, ST_SADDR, ST_SDATA, ST_DONE
  } dma_st_e;
endpackage

// File: rtl/pkt_dma_ring.sv
module pkt_dma_ring #(
  parameter int unsigned AW    = 4,
  parameter int unsigned BLK_W = 4,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [CNT_W-1:0] push_cnt_i,
  input  logic [BLK_W-1:0] push_blk_i,
  input  logic             pop_i,
  output logic             full_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] head_cnt_o,
  output logic [BLK_W-1:0] head_blk_o,
  output logic [AW-1:0]    head_slot_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [AW:0]      wr_q, rd_q;
  logic [CNT_W-1:0] cnt_mem [DEPTH];
  logic [BLK_W-1:0] blk_mem [DEPTH];

  // wrap bit separates full from empty
  assign empty_o     = (wr_q == rd_q);
  assign full_o      = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
  assign head_cnt_o  = cnt_mem[rd_q[AW-1:0]];
  assign head_blk_o  = blk_mem[rd_q[AW-1:0]];
  assign head_slot_o = rd_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push_i && !full_o) wr_q <= wr_q + (AW+1)'(1);
      if (pop_i && !empty_o) rd_q <= rd_q + (AW+1)'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) begin
      cnt_mem[wr_q[AW-1:0]] <= push_cnt_i;
      blk_mem[wr_q[AW-1:0]] <= push_blk_i;
    end
  end
endmodule

// File: rtl/pkt_dma_blkmap.sv
module pkt_dma_blkmap #(
  parameter int unsigned BLK_W = 4,
  localparam int unsigned NBLK = 1 << BLK_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [BLK_W-1:0] set_blk_i,
  input  logic             clr_i,
  input  logic [BLK_W-1:0] clr_blk_i,
  output logic [NBLK-1:0]  used_o
);
  for (genvar b = 0; b < NBLK; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   used_o[b] <= 1'b0;
      else if (set_i && set_blk_i == BLK_W'(b))      used_o[b] <= 1'b1;
      else if (clr_i && clr_blk_i == BLK_W'(b))      used_o[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/pkt_dma_engine.sv
module pkt_dma_engine
  import pkt_dma_pkg::*;
#(
  parameter int unsigned AW        = 4,
  parameter int unsigned BLK_W     = 4,
  parameter int unsigned BLK_BYTES = 256
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic [31:0]                            host_base_i,
  input  logic                                   empty_i,
  input  logic [CNT_W-1:0]                       head_cnt_i,
  input  logic [BLK_W-1:0]                       head_blk_i,
  input  logic [AW-1:0]                          head_slot_i,
  output logic                                   done_o,
  output logic [BLK_W-1:0]                       rel_blk_o,
  output logic                                   lrd_req_o,
  output logic [BLK_W+$clog2(BLK_BYTES/4)-1:0]   lrd_addr_o,
  input  logic                                   lrd_gnt_i,
  input  logic [WORD_W-1:0]                      lrd_data_i,
  output logic                                   mw_req_o,
  output logic                                   mw_single_o,
  output logic [31:0]                            mw_addr_o,
  input  logic                                   mw_gnt_i,
  output logic                                   mw_valid_o,
  output logic [WORD_W-1:0]                      mw_data_o,
  output logic                                   mw_last_o,
  input  logic                                   mw_ready_i
);
  localparam int unsigned BLK_LOG   = $clog2(BLK_BYTES);
  localparam int unsigned WIDX_W    = $clog2(BLK_BYTES / 4);
  localparam int unsigned BEAT_W    = $clog2(BURST_LEN);
  localparam int unsigned RSV_BYTES = RSV_WORDS * 4;
  localparam int unsigned BRST_LOG  = $clog2(BURST_LEN * 4);
  localparam int unsigned NW_W      = CNT_W + 1;

  dma_st_e             st_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [BLK_W-1:0]    blk_q;
  logic [AW-1:0]       slot_q;
  logic [NW_W-1:0]     nwords_q, nbursts_q, burst_q;
  logic [BEAT_W-1:0]   beat_q;
  logic                have_q;
  logic [WORD_W-1:0]   dat_q;

  logic [NW_W-1:0]        head_words, head_bursts;
  logic [NW_W+BEAT_W-1:0] word_idx;
  logic                   word_live, last_beat;
  logic [31:0]            blk_base, burst_addr;
  logic [WORD_W-1:0]      stat_word;

  assign head_words  = (NW_W'(head_cnt_i) + NW_W'(3)) >> 2;
  assign head_bursts = (head_words + NW_W'(BURST_LEN - 1)) >> BEAT_W;
  assign word_idx    = {burst_q, beat_q};
  assign word_live   = word_idx < (NW_W+BEAT_W)'(nwords_q);
  assign last_beat   = (beat_q == BEAT_W'(BURST_LEN - 1));
  assign blk_base    = host_base_i + (32'(slot_q) << BLK_LOG);
  assign burst_addr  = blk_base + RSV_BYTES + (32'(burst_q) << BRST_LOG);

  always_comb begin
    stat_word = '0;
    stat_word[CNT_W-1:0]      = cnt_q;
    stat_word[CNT_W +: BLK_W] = blk_q;
  end

  assign lrd_req_o   = (st_q == ST_BDATA) && !have_q && word_live;
  assign lrd_addr_o  = {blk_q, word_idx[WIDX_W-1:0]};
  assign mw_req_o    = (st_q == ST_BADDR) || (st_q == ST_SADDR);
  assign mw_single_o = (st_q == ST_SADDR);
  assign mw_addr_o   = mw_single_o ? blk_base : burst_addr;
  assign mw_valid_o  = ((st_q == ST_BDATA) && have_q) || (st_q == ST_SDATA);
  assign mw_last_o   = ((st_q == ST_BDATA) && have_q && last_beat) || (st_q == ST_SDATA);
  assign mw_data_o   = (st_q == ST_SDATA) ? stat_word : dat_q;
  assign done_o      = (st_q == ST_DONE);
  assign rel_blk_o   = blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      blk_q     <= '0;
      slot_q    <= '0;
      nwords_q  <= '0;
      nbursts_q <= '0;
      burst_q   <= '0;
      beat_q    <= '0;
      have_q    <= 1'b0;
      dat_q     <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (!empty_i) begin
          cnt_q     <= head_cnt_i;
          blk_q     <= head_blk_i;
          slot_q    <= head_slot_i;
          nwords_q  <= head_words;
          nbursts_q <= head_bursts;
          burst_q   <= '0;
          beat_q    <= '0;
          have_q    <= 1'b0;
          st_q      <= (head_bursts == '0) ? ST_SADDR : ST_BADDR;
        end
        ST_BADDR: if (mw_gnt_i) st_q <= ST_BDATA;
        ST_BDATA: begin
          if (!have_q) begin
            if (!word_live) begin
              dat_q  <= '0;            // pad beat
              have_q <= 1'b1;
            end else if (lrd_gnt_i) begin
              dat_q  <= lrd_data_i;
              have_q <= 1'b1;
            end
          end else if (mw_ready_i) begin
            have_q <= 1'b0;
            if (last_beat) begin
              beat_q  <= '0;
              burst_q <= burst_q + NW_W'(1);
              st_q    <= (burst_q + NW_W'(1) == nbursts_q) ? ST_SADDR : ST_BADDR;
            end else begin
              beat_q <= beat_q + BEAT_W'(1);
            end
          end
        end
        ST_SADDR: if (mw_gnt_i)   st_q <= ST_SDATA;
        ST_SDATA: if (mw_ready_i) st_q <= ST_DONE;
        ST_DONE:  st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pkt_host_dma.sv
module pkt_host_dma
  import pkt_dma_pkg::*;
#(
  parameter int unsigned RING_AW   = 4,
  parameter int unsigned BLK_W     = 4,
  parameter int unsigned BLK_BYTES = 256
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [31:0]                          host_base_i,
  input  logic                                 push_valid_i,
  output logic                                 push_ready_o,
  input  logic [CNT_W-1:0]                     push_cnt_i,
  input  logic [BLK_W-1:0]                     push_blk_i,
  output logic                                 lrd_req_o,
  output logic [BLK_W+$clog2(BLK_BYTES/4)-1:0] lrd_addr_o,
  input  logic                                 lrd_gnt_i,
  input  logic [WORD_W-1:0]                    lrd_data_i,
  output logic                                 mw_req_o,
  output logic                                 mw_single_o,
  output logic [31:0]                          mw_addr_o,
  input  logic                                 mw_gnt_i,
  output logic                                 mw_valid_o,
  output logic [WORD_W-1:0]                    mw_data_o,
  output logic                                 mw_last_o,
  input  logic                                 mw_ready_i,
  output logic                                 irq_o,
  output logic [(1<<BLK_W)-1:0]                blk_used_o
);
  logic               full, empty, done;
  logic [CNT_W-1:0]   head_cnt;
  logic [BLK_W-1:0]   head_blk, rel_blk;
  logic [RING_AW-1:0] head_slot;

  assign push_ready_o = !full;
  assign irq_o        = done;

  pkt_dma_ring #(.AW(RING_AW), .BLK_W(BLK_W), .CNT_W(CNT_W)) u_ring (
    .clk_i, .rst_ni,
    .push_i      (push_valid_i),
    .push_cnt_i,
    .push_blk_i,
    .pop_i       (done),
    .full_o      (full),
    .empty_o     (empty),
    .head_cnt_o  (head_cnt),
    .head_blk_o  (head_blk),
    .head_slot_o (head_slot)
  );

  pkt_dma_blkmap #(.BLK_W(BLK_W)) u_map (
    .clk_i, .rst_ni,
    .set_i     (push_valid_i && push_ready_o),
    .set_blk_i (push_blk_i),
    .clr_i     (done),
    .clr_blk_i (rel_blk),
    .used_o    (blk_used_o)
  );

  pkt_dma_engine #(.AW(RING_AW), .BLK_W(BLK_W), .BLK_BYTES(BLK_BYTES)) u_eng (
    .clk_i, .rst_ni, .host_base_i,
    .empty_i     (empty),
    .head_cnt_i  (head_cnt),
    .head_blk_i  (head_blk),
    .head_slot_i (head_slot),
    .done_o      (done),
    .rel_blk_o   (rel_blk),
    .lrd_req_o, .lrd_addr_o, .lrd_gnt_i, .lrd_data_i,
    .mw_req_o, .mw_single_o, .mw_addr_o, .mw_gnt_i,
    .mw_valid_o, .mw_data_o, .mw_last_o, .mw_ready_i
  );
endmodule

// File: rtl/pkt_host_dma_chk.sv
module pkt_host_dma_chk #(
  parameter int unsigned BLK_BYTES = 256,
  parameter int unsigned LA_W      = 10,
  parameter int unsigned BLK_W     = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [31:0]            host_base_i,
  input logic                   push_valid_i,
  input logic                   push_ready_o,
  input logic [BLK_W-1:0]       push_blk_i,
  input logic                   lrd_req_o,
  input logic [LA_W-1:0]        lrd_addr_o,
  input logic                   lrd_gnt_i,
  input logic                   mw_req_o,
  input logic                   mw_single_o,
  input logic [31:0]            mw_addr_o,
  input logic                   mw_gnt_i,
  input logic                   mw_valid_o,
  input logic [31:0]            mw_data_o,
  input logic                   mw_last_o,
  input logic                   mw_ready_i,
  input logic                   irq_o,
  input logic [(1<<BLK_W)-1:0]  blk_used_o
);
  logic [31:0] blk_off;
  assign blk_off = (mw_addr_o - host_base_i) & 32'(BLK_BYTES - 1);

  // R10
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mw_req_o && !mw_gnt_i |=> mw_req_o && $stable(mw_addr_o) && $stable(mw_single_o));
  // R10
  beat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mw_valid_o && !mw_ready_i |=> mw_valid_o && $stable(mw_data_o) && $stable(mw_last_o));
  // R10
  lrd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lrd_req_o && !lrd_gnt_i |=> lrd_req_o && $stable(lrd_addr_o));
  // R6
  rsv_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mw_req_o |-> (blk_off == 32'd0) || (blk_off >= 32'd32));
  // R7
  stat_word0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mw_req_o && mw_single_o |-> blk_off == 32'd0);
  // R8
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  // R8
  irq_after_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(mw_valid_o && mw_ready_i && mw_last_o) && !mw_req_o && !mw_valid_o);
  // R9
  blk_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_valid_i && push_ready_o |=> blk_used_o[$past(push_blk_i)]);
endmodule

bind pkt_host_dma pkt_host_dma_chk #(
  .BLK_BYTES (BLK_BYTES),
  .LA_W      (BLK_W + $clog2(BLK_BYTES / 4)),
  .BLK_W     (BLK_W)
) u_chk (.*);

// File: tb/pkt_host_dma_bench.sv
module pkt_host_dma_bench;
  localparam int PERIOD = 10;
  localparam int SLOTS  = 16;
  localparam int BWORDS = 64;
  localparam int HWORDS = SLOTS * BWORDS;
  localparam logic [31:0] BASE = 32'h0010_0000;
  localparam logic [31:0] SENT = 32'hDEAD_BEEF;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [31:0] host_base_i = BASE;
  logic        push_valid_i = 1'b0, push_ready_o;
  logic [15:0] push_cnt_i = '0;
  logic [3:0]  push_blk_i = '0;
  logic        lrd_req_o, lrd_gnt_i = 1'b0;
  logic [9:0]  lrd_addr_o;
  logic [31:0] lrd_data_i = '0;
  logic        mw_req_o, mw_single_o, mw_gnt_i = 1'b0;
  logic [31:0] mw_addr_o, mw_data_o;
  logic        mw_valid_o, mw_last_o, mw_ready_i = 1'b0;
  logic        irq_o;
  logic [15:0] blk_used_o;

  pkt_host_dma u_pkt_host_dma (.*);

  always #(PERIOD/2) clk_i = ~clk_i;

  int nvec = 0, nfail = 0;
  logic [31:0] hmem [HWORDS];
  int q_cnt [64], q_blk [64], q_slot [64];
  int q_head = 0, q_tail = 0, pushes = 0;
  int irq_total = 0, idle_viol = 0, range_viol = 0;
  int aph_n = 0, beats = 0, lasts = 0, last_idx = -1, cur_idx = 0;
  logic [31:0] aph_addr [16];
  logic [15:0] lf = 16'hACE1;
  bit fast = 1'b1, mw_hold = 1'b0, drv_push = 1'b0, last_acc = 1'b0;
  int drv_cnt = 0, drv_blk = 0;
  bit pend_set = 0, pend_clr = 0;
  int pend_set_blk = 0, pend_clr_blk = 0;
  bit done_flag = 0;

  function automatic logic [31:0] lword(input int a);
    return (32'(a) * 32'h0001_0103) ^ 32'h3C5A_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic verify_xfer();
    int cnt, blk, slot, nw, nb, sb, bad;
    logic [31:0] fa, fe;
    cnt = q_cnt[q_head]; blk = q_blk[q_head]; slot = q_slot[q_head];
    q_head = (q_head + 1) % 64;
    nw = (cnt + 3) / 4; nb = (nw + 7) / 8; sb = slot * BWORDS;
    chk(hmem[sb] == 32'((blk << 16) | cnt), "R7 status word", hmem[sb], 32'((blk << 16) | cnt));
    chk(last_idx == sb, "R7 status written last", 32'(last_idx), 32'(sb));
    bad = 0;
    for (int i = 1; i < 8; i++) if (hmem[sb+i] !== SENT) bad++;
    chk(bad == 0, "R6 reserved words touched", 32'(bad), 0);
    bad = 0; fa = 0; fe = 0;
    for (int w = 0; w < nw; w++)
      if (hmem[sb+8+w] !== lword(blk * BWORDS + w)) begin
        if (bad == 0) begin fa = hmem[sb+8+w]; fe = lword(blk * BWORDS + w); end
        bad++;
      end
    chk(bad == 0, "R3 payload", fa, fe);
    bad = 0;
    for (int w = nw; w < nb * 8; w++) if (hmem[sb+8+w] !== 32'h0) bad++;
    chk(bad == 0, "R5 pad words", 32'(bad), 0);
    bad = 0;
    for (int w = nb * 8; w < BWORDS - 8; w++) if (hmem[sb+8+w] !== SENT) bad++;
    chk(bad == 0, "R6 words past final burst", 32'(bad), 0);
    chk(beats == nb * 8 + 1, "R4 beat count", 32'(beats), 32'(nb * 8 + 1));
    chk(lasts == nb + 1, "R4 last flags", 32'(lasts), 32'(nb + 1));
    chk(aph_n == nb + 1, "R4 address phases", 32'(aph_n), 32'(nb + 1));
    bad = 0;
    for (int k = 0; k < nb && k < 15; k++)
      if (aph_addr[k] !== BASE + 32'(slot * 256 + 32 + 32 * k)) bad++;
    chk(bad == 0, "R4 burst addresses", 32'(bad), 0);
    if (nb < 16)
      chk(aph_addr[nb] === BASE + 32'(slot * 256), "R7 status address", aph_addr[nb], BASE + 32'(slot * 256));
    chk(range_viol == 0, "R4 write inside host blocks", 32'(range_viol), 0);
    aph_n = 0; beats = 0; lasts = 0; last_idx = -1; range_viol = 0;
  endtask

  task automatic step();
    @(negedge clk_i);
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    mw_gnt_i     = mw_hold ? 1'b0 : (fast || lf[0] || lf[3]);
    mw_ready_i   = fast || lf[5] || lf[7];
    lrd_gnt_i    = fast || lf[9] || lf[11];
    lrd_data_i   = lword(int'(lrd_addr_o));
    push_valid_i = drv_push;
    push_cnt_i   = 16'(drv_cnt);
    push_blk_i   = 4'(drv_blk);
    #1;
    if (!rst_ni) return;
    if (pend_set) begin
      chk(blk_used_o[pend_set_blk] == 1'b1, "R9 block marked in use", 32'(blk_used_o), 0);
      pend_set = 0;
    end
    if (pend_clr) begin
      chk(blk_used_o[pend_clr_blk] == 1'b0, "R8 block released", 32'(blk_used_o), 0);
      chk(irq_o == 1'b0, "R8 single-cycle irq", 32'(irq_o), 0);
      pend_clr = 0;
    end
    if ((mw_req_o || mw_valid_o || lrd_req_o) && q_head == q_tail) idle_viol++;
    last_acc = 0;
    if (push_valid_i && push_ready_o) begin
      last_acc = 1;
      q_cnt[q_tail] = drv_cnt; q_blk[q_tail] = drv_blk; q_slot[q_tail] = pushes % SLOTS;
      for (int i = 0; i < BWORDS; i++) hmem[(pushes % SLOTS) * BWORDS + i] = SENT;
      q_tail = (q_tail + 1) % 64;
      pushes++;
      pend_set = 1; pend_set_blk = drv_blk;
    end
    if (mw_req_o && mw_gnt_i) begin
      if (aph_n < 16) aph_addr[aph_n] = mw_addr_o;
      aph_n++;
      cur_idx = int'((mw_addr_o - BASE) >> 2);
    end
    if (mw_valid_o && mw_ready_i) begin
      if (cur_idx >= 0 && cur_idx < HWORDS) hmem[cur_idx] = mw_data_o;
      else range_viol++;
      last_idx = cur_idx;
      cur_idx++;
      beats++;
      if (mw_last_o) lasts++;
    end
    if (irq_o) begin
      irq_total++;
      pend_clr = 1; pend_clr_blk = q_blk[q_head];
      if (q_head != q_tail) verify_xfer();
      else chk(1'b0, "R1 completion without descriptor", 1, 0);
    end
  endtask

  task automatic push(input int cnt, input int blk);
    drv_push = 1; drv_cnt = cnt; drv_blk = blk;
    step();
    drv_push = 0;
  endtask

  task automatic wait_irq(input int target);
    int n = 0;
    while (irq_total < target && n < 20000) begin step(); n++; end
    chk(irq_total >= target, "R8 completion reached", 32'(irq_total), 32'(target));
  endtask

  initial begin
    for (int i = 0; i < HWORDS; i++) hmem[i] = SENT;
    // R11 reset state
    repeat (3) step();
    chk(!mw_req_o && !mw_valid_o && !lrd_req_o, "R11 idle in reset", {29'd0, mw_req_o, mw_valid_o, lrd_req_o}, 0);
    chk(!irq_o && blk_used_o == '0, "R11 irq/bitmap in reset", {15'd0, irq_o, blk_used_o}, 0);
    chk(push_ready_o, "R11 ready in reset", 32'(push_ready_o), 1);
    @(negedge clk_i); rst_ni = 1'b1;
    repeat (20) step();
    chk(idle_viol == 0, "R1 idle with empty ring", 32'(idle_viol), 0);

    // R2 fill the ring with the host stalled
    mw_hold = 1; fast = 0;
    for (int k = 0; k < 16; k++) begin
      push(k * 13 + 1, k);
      chk(last_acc, "R2 push accepted", 32'(last_acc), 1);
    end
    step();
    chk(!push_ready_o, "R2 ring full", 32'(push_ready_o), 0);
    drv_push = 1; drv_cnt = 40; drv_blk = 3;
    repeat (4) begin step(); chk(!last_acc, "R2 push ignored when full", 32'(last_acc), 0); end
    drv_push = 0;
    mw_hold = 0;
    wait_irq(16);
    repeat (200) step();
    chk(idle_viol == 0, "R2 no transfer from ignored push", 32'(idle_viol), 0);
    chk(irq_total == 16, "R2 completions equal accepted pushes", 32'(irq_total), 16);

    // sweep all byte counts
    for (int c = 0; c <= 224; c++) begin
      fast = (c % 3 == 0);
      push(c, c % 16);
      wait_irq(16 + c + 1);
      step();
    end
    repeat (50) step();
    chk(idle_viol == 0, "R1 idle after sweep", 32'(idle_viol), 0);
    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #(PERIOD * 190000);
    if (!done_flag) begin
      nvec++; nfail++;
      $display("FAIL R8 watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule